// File: doc/BRIEF.md
# Power and Operating Mode Controller

This block is the state machine that moves the chip between its power states. It watches a comparator bit that reports whether the supply is above the brownout threshold. It also watches a software request to enter low-power stop, four wake event inputs, and the two supply-monitor control bits. From these it drives three enables and a state code:

- CPU enable
- digital-core power enable
- supply-monitor run enable

The analog comparators, the oscillator and the reset sequencer sit outside the block and appear here only as inputs.

There are five states:

| State | Code | Role |
|---|---|---|
| `PM_POR` | 0 | Power-on |
| `PM_SETTLE` | 1 | Oscillator settling delay, lasting `SETTLE_CYC` cycles |
| `PM_RUN` | 2 | CPU running |
| `PM_STOP` | 3 | Digital core powered off, analog still on |
| `PM_BROWN` | 4 | CPU disabled while the supply is low, analog active |

The named transitions are:

- **supply-up**: `PM_POR` to `PM_SETTLE`.
- **settled**: `PM_SETTLE` to `PM_RUN`.
- **sleep**: `PM_RUN` to `PM_STOP`.
- **wake**: `PM_STOP` to `PM_RUN`.
- **sag**: `PM_SETTLE`, `PM_RUN` or `PM_STOP` to `PM_BROWN`.
- **recover**: `PM_BROWN` to `PM_SETTLE`.

Software sets a stop flag. The flag is honoured from `PM_RUN` and is cleared by hardware on wake and on sag, so a wake never falls straight back into stop.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_code` is 0 (`PM_POR`), `cpu_en` is 0, `core_pwr_en` is 1 and `stop_bit` is 0.
- R2: In `PM_POR` the state stays at code 0 while `supply_ok` is 0. After a clock edge that samples `supply_ok` at 1, the state is `PM_SETTLE` (code 1).
- R3: `PM_SETTLE` lasts exactly `SETTLE_CYC` cycles while the supply stays up, then the state becomes `PM_RUN` (code 2). `cpu_en` is 1 only in `PM_RUN`.
- R4: A clock edge that samples `supply_ok` at 0 in `PM_SETTLE`, `PM_RUN` or `PM_STOP` moves the state to `PM_BROWN` (code 4) and clears `stop_bit`. Sag takes priority over wake and over sleep. In `PM_BROWN`, `cpu_en` is 0 and `core_pwr_en` is 1.
- R5: `PM_BROWN` holds while `supply_ok` is 0. The first edge with `supply_ok` at 1 goes to `PM_SETTLE`, which then runs the full `SETTLE_CYC` delay again.
- R6: If `stop_set` is sampled high in `PM_RUN`, `stop_bit` reads 1 after that edge and the state is `PM_STOP` (code 3) after the next edge. In `PM_STOP`, `core_pwr_en` and `cpu_en` are both 0.
- R7: `stop_set` is ignored in `PM_POR`, `PM_SETTLE` and `PM_BROWN`: `stop_bit` stays 0.
- R8: In `PM_STOP` with the supply up, any one of `wake_port`, `wake_twi`, `wake_mon` or `wake_ext` returns the state to `PM_RUN` after one edge, which is well within 10 cycles. `stop_bit` reads 0 at the same time.
- R9: Wake inputs have no effect in `PM_RUN`, `PM_POR`, `PM_SETTLE` and `PM_BROWN`.
- R10: `mon_run` equals `mon_en && mon_stop_en` in `PM_STOP` and equals `mon_en` in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above brownout threshold |
| stop_set | input | 1 | Software request to set the stop flag |
| wake_port | input | 1 | Port pin interrupt wake |
| wake_twi | input | 1 | Two-wire start-condition interrupt wake |
| wake_mon | input | 1 | Supply-monitor interrupt wake |
| wake_ext | input | 1 | External reset wake |
| mon_en | input | 1 | Supply-monitor enable |
| mon_stop_en | input | 1 | Keep the supply monitor running in stop |
| cpu_en | output | 1 | CPU clock/run enable |
| core_pwr_en | output | 1 | Digital core power enable |
| mon_run | output | 1 | Supply monitor active |
| stop_bit | output | 1 | Stop flag as software reads it |
| state_code | output | 3 | Current state code (0..4) |

## Verification
The bench targets the following cases, each with the failure a faulty design would show:

- **Sag arriving with a wake or a sleep request.** A design with the wrong priority would come back to `PM_RUN` or enter `PM_STOP` on a failing supply.
- **Sag in the middle of the settling delay, followed by recovery.** A counter that is not restarted would release the CPU early.
- **The settling delay exactly.** An off-by-one delay shows up as `cpu_en` rising one cycle early or late.
- **Each wake source used alone.** A dropped source leaves the chip asleep.
- **A stop flag not cleared on wake.** The design would drop straight back into `PM_STOP`.
- **Stop requests and wakes in the wrong states.** A design that accepts them there would show a stray `stop_bit` or a stray change of state.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
    localparam int STATE_W = 3;
    localparam int N_WAKE  = 4;

    typedef enum logic [STATE_W-1:0] {
        PM_POR    = 3'd0,
        PM_SETTLE = 3'd1,
        PM_RUN    = 3'd2,
        PM_STOP   = 3'd3,
        PM_BROWN  = 3'd4
    } pm_state_e;
endpackage

// File: rtl/pmode_settle_cnt.sv
module pmode_settle_cnt #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // counter restarts whenever the settle state is left
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);
endmodule

// File: rtl/pmode_wake_merge.sv
module pmode_wake_merge #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] src,
    output logic             any
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | src[i];
    end
    assign any = chain[N_SRC];
endmodule

// File: rtl/pmode_stop_flag.sv
module pmode_stop_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // clear wins over set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr_req) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                supply_ok,
    input  logic                stop_set,
    input  logic                wake_port,
    input  logic                wake_twi,
    input  logic                wake_mon,
    input  logic                wake_ext,
    input  logic                mon_en,
    input  logic                mon_stop_en,
    output logic                cpu_en,
    output logic                core_pwr_en,
    output logic                mon_run,
    output logic                stop_bit,
    output logic [STATE_W-1:0]  state_code
);
    pm_state_e state, nxt;
    logic      settle_done;
    logic      wake_any;
    logic      flag_set, flag_clr;

    pmode_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == PM_SETTLE),
        .done   (settle_done)
    );

    pmode_wake_merge #(.N_SRC(N_WAKE)) u_wake (
        .src ({wake_ext, wake_mon, wake_twi, wake_port}),
        .any (wake_any)
    );

    assign flag_set = stop_set && (state == PM_RUN);
    assign flag_clr = (nxt == PM_BROWN) || ((state == PM_STOP) && (nxt == PM_RUN));

    pmode_stop_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (flag_set),
        .clr_req (flag_clr),
        .flag    (stop_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PM_POR;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            PM_POR: begin
                if (supply_ok) nxt = PM_SETTLE;         // supply-up
            end
            PM_SETTLE: begin
                if (!supply_ok)       nxt = PM_BROWN;   // sag
                else if (settle_done) nxt = PM_RUN;     // settled
            end
            PM_RUN: begin
                if (!supply_ok)    nxt = PM_BROWN;      // sag
                else if (stop_bit) nxt = PM_STOP;       // sleep
            end
            PM_STOP: begin
                if (!supply_ok)    nxt = PM_BROWN;      // sag
                else if (wake_any) nxt = PM_RUN;        // wake
            end
            PM_BROWN: begin
                if (supply_ok) nxt = PM_SETTLE;         // recover
            end
            default: nxt = PM_POR;
        endcase
    end

    // outputs
    always_comb begin
        cpu_en      = 1'b0;
        core_pwr_en = 1'b1;
        mon_run     = mon_en;
        unique case (state)
            PM_POR, PM_SETTLE, PM_BROWN: begin
                cpu_en = 1'b0;
            end
            PM_RUN: begin
                cpu_en = 1'b1;
            end
            PM_STOP: begin
                core_pwr_en = 1'b0;
                mon_run     = mon_en && mon_stop_en;
            end
            default: begin
                cpu_en = 1'b0;
            end
        endcase
    end

    assign state_code = state;
endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       stop_set,
    input logic       wake_port,
    input logic       wake_twi,
    input logic       wake_mon,
    input logic       wake_ext,
    input logic       mon_en,
    input logic       mon_stop_en,
    input logic       cpu_en,
    input logic       core_pwr_en,
    input logic       mon_run,
    input logic       stop_bit,
    input logic [2:0] state_code
);
    localparam logic [2:0] C_POR = 3'd0, C_SET = 3'd1, C_RUN = 3'd2,
                           C_STP = 3'd3, C_BRN = 3'd4;

    logic woke;
    assign woke = wake_port || wake_twi || wake_mon || wake_ext;

    // R2
    supply_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_POR && supply_ok) |=> state_code == C_SET);

    // R3
    cpu_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_en) |-> ($past(state_code) == C_SET || $past(state_code) == C_STP));

    // R4
    sag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && (state_code == C_SET || state_code == C_RUN || state_code == C_STP))
        |=> (state_code == C_BRN && !stop_bit));

    // R6
    stop_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == C_STP |-> (!core_pwr_en && !cpu_en));

    // R7
    stop_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_set && (state_code == C_POR || state_code == C_SET || state_code == C_BRN))
        |=> !stop_bit);

    // R8
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_STP && supply_ok && woke) |=> (state_code == C_RUN && !stop_bit));

    // R10
    mon_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_run |-> mon_en);

    // R10
    mon_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == C_STP && !mon_stop_en) |-> !mon_run);
endmodule

bind pmode_ctrl pmode_ctrl_chk u_chk (.*);

// File: tb/pmode_ctrl_test.sv
module pmode_ctrl_test;
    localparam int SC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, stop_set = 1'b0;
    logic wake_port = 1'b0, wake_twi = 1'b0, wake_mon = 1'b0, wake_ext = 1'b0;
    logic mon_en = 1'b0, mon_stop_en = 1'b0;
    logic cpu_en, core_pwr_en, mon_run, stop_bit;
    logic [2:0] state_code;

    pmode_ctrl #(.SETTLE_CYC(SC)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .stop_set(stop_set),
        .wake_port(wake_port), .wake_twi(wake_twi), .wake_mon(wake_mon),
        .wake_ext(wake_ext), .mon_en(mon_en), .mon_stop_en(mon_stop_en),
        .cpu_en(cpu_en), .core_pwr_en(core_pwr_en), .mon_run(mon_run),
        .stop_bit(stop_bit), .state_code(state_code)
    );

    always #10 clk = ~clk;

    int    vectors = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string req = "R1";

    // reference model
    int ms = 0;
    int left = 0;
    bit mstop = 1'b0;

    task automatic model_edge();
        bit anyw;
        anyw = wake_port | wake_twi | wake_mon | wake_ext;
        if (!rst_n) begin
            ms = 0; mstop = 0;
        end else begin
            case (ms)
                0: if (supply_ok) begin ms = 1; left = SC; end
                1: if (!supply_ok) ms = 4;
                   else begin
                       left--;
                       if (left == 0) ms = 2;
                   end
                2: if (!supply_ok) begin ms = 4; mstop = 0; end
                   else if (mstop) ms = 3;
                   else if (stop_set) mstop = 1;
                3: if (!supply_ok) begin ms = 4; mstop = 0; end
                   else if (anyw) begin ms = 2; mstop = 0; end
                4: if (supply_ok) begin ms = 1; left = SC; end
                default: ms = 0;
            endcase
        end
    endtask

    task automatic cmp1(string name, int act, int exp);
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual %0d expected %0d", req, name, act, exp);
        end
    endtask

    task automatic compare();
        vectors++;
        cmp1("state_code", int'(state_code), ms);
        cmp1("cpu_en", int'(cpu_en), (ms == 2) ? 1 : 0);
        cmp1("core_pwr_en", int'(core_pwr_en), (ms == 3) ? 0 : 1);
        cmp1("mon_run", int'(mon_run), (ms == 3) ? int'(mon_en & mon_stop_en) : int'(mon_en));
        cmp1("stop_bit", int'(stop_bit), int'(mstop));
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wake_pulse(int which);
        wake_port = (which == 0); wake_twi = (which == 1);
        wake_mon  = (which == 2); wake_ext = (which == 3);
        step(1);
        wake_port = 0; wake_twi = 0; wake_mon = 0; wake_ext = 0;
    endtask

    task automatic go_stop();
        stop_set = 1; step(1); stop_set = 0; step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        req = "R1"; compare();
        step(2);
        @(negedge clk); rst_n = 1'b1;
        req = "R2"; step(3);
        req = "R7"; stop_set = 1; step(2); stop_set = 0;
        req = "R9"; wake_ext = 1; step(1); wake_ext = 0;
        req = "R2"; supply_ok = 1; step(1);
        req = "R3"; step(SC + 2);
        req = "R9"; for (int w = 0; w < 4; w++) wake_pulse(w);
        step(1);
        req = "R10"; mon_en = 1; mon_stop_en = 0; step(1);
        req = "R6"; go_stop(); step(2);
        req = "R10"; mon_stop_en = 1; step(1); mon_en = 0; step(1); mon_en = 1;
        req = "R8"; wake_pulse(0); step(2);
        for (int w = 1; w < 4; w++) begin
            req = "R6"; go_stop(); step(1);
            req = "R8"; wake_pulse(w); step(3);
        end
        req = "R4"; go_stop();
        supply_ok = 0; wake_mon = 1; step(1); wake_mon = 0;
        req = "R5"; step(3);
        req = "R7"; stop_set = 1; step(1); stop_set = 0;
        req = "R5"; supply_ok = 1; step(3);
        req = "R4"; supply_ok = 0; step(2);
        req = "R5"; supply_ok = 1; step(SC + 2);
        req = "R4"; stop_set = 1; step(1); stop_set = 0; supply_ok = 0; step(2);
        req = "R4"; supply_ok = 1; step(SC + 1);
        stop_set = 1; supply_ok = 0; step(1); stop_set = 0; step(1);
        req = "R5"; supply_ok = 1; step(SC + 3);
        req = "R1"; rst_n = 0; step(2); rst_n = 1; step(2);
        finish_run();
    end
endmodule